// File: doc/BRIEF.md
# Missing Clock Guard with Delayed-Reset NMI

This block watches a primary clock by sampling it on an always-running backup oscillator. If the primary clock stops toggling, the block moves the system clock output over to a slow limp clock, so the logic downstream keeps running. At the same moment it raises a non-maskable interrupt flag and a sticky missing-clock status bit.

A control bit sets what happens next. In one setting the device reset fires at once. In the other, a counter on the backup clock starts counting. If software does not clear the interrupt before the counter reaches a programmed period, the block resets the device.

Software uses a small register port with four word addresses:
- 0: status and clear
- 1: control
- 2: period
- 3: counter readback

The reset output is a fixed-width pulse. The pulse also returns the block's own flags, counter and limp state to zero.

Top module: `clkloss_nmi_guard`

## Requirements
- R1: `pri_clk` passes through three backup-clock register stages before its rising edges are seen. Clock loss is declared 19 backup cycles after the last rising edge driven onto `pri_clk`. Rising edges that arrive no more than 16 backup cycles apart never declare loss. Limp state reads as bit 2 of address 0.
- R2: `sys_clk` equals `pri_clk` while limp state is 0 and equals `limp_clk` while it is 1. Once set, limp state holds until a reset pulse or `rst_n`.
- R3: The NMI flag (bit 0 of address 0) sets on the same backup edge as the limp state.
- R4: The missing-clock bit (bit 1 of address 0) sets together with the NMI flag. It stays set when software clears the NMI flag. It is 1 whenever the NMI flag is 1.
- R5: With bit 0 of address 1 at 1 (immediate policy), `rst_out` goes high one backup cycle after the NMI flag first reads 1.
- R6: With bit 0 of address 1 at 0 (delayed policy), the counter behaves as follows:
  - It reads at address 3.
  - It starts at 0 when the NMI flag sets.
  - It counts up by one on every backup cycle while the flag is set.
  - `rst_out` goes high P+1 cycles after the flag first reads 1, where P is the period at address 2.
- R7: Writing address 0 with bit 0 at 1 clears the NMI flag and the counter to 0, and no reset follows. Writing address 0 with bit 0 at 0 changes nothing.
- R8: `rst_out` is a pulse exactly 8 backup cycles wide.
- R9: A reset pulse clears the NMI flag, the missing-clock bit, the limp state and the counter. Control and period keep their values.
- R10: When `rst_n` is low at a backup edge, every register is cleared: status 0, control 0, period 100, counter 0 and `rst_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bk_clk | input | 1 | Always-running backup clock; every register runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_clk | input | 1 | Primary clock being watched, sampled as data |
| limp_clk | input | 1 | Fallback clock switched to on loss |
| sys_clk | output | 1 | Selected system clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data (combinational on `addr`) |
| rst_out | output | 1 | Device reset pulse |

## Verification
A stuck or miscounted gap counter shows up in two ways. It can declare loss while rising edges arrive every 16 cycles or less. Or it can move the 19-cycle detection point, which shows on the status bits at the first sample after that point. A counter that starts at the wrong value or steps wrongly moves the `rst_out` rising edge away from P+1 cycles after the flag, and the bench times this exactly over random periods. Bad pulse or clear state shows at the port in one of three ways:
- a pulse width other than 8;
- status bits still set after a pulse;
- a reset firing after software cleared the flag. This case is watched for longer than the programmed period.

// File: rtl/cng_pkg.sv
// Package: shared register addresses and status bit positions for the
// missing clock guard. Assumes a 2-bit word address.
package cng_pkg;
    typedef enum logic [1:0] {
        A_STAT   = 2'd0,
        A_CTRL   = 2'd1,
        A_PERIOD = 2'd2,
        A_COUNT  = 2'd3
    } reg_addr_e;

    localparam int ST_NMI  = 0;
    localparam int ST_MISS = 1;
    localparam int ST_LIMP = 2;
endpackage

// File: rtl/cng_edge_watch.sv
// Edge watcher: synchronises the primary clock into the backup domain,
// counts backup cycles since its last rising edge, and latches limp state
// after LOSS_CYC cycles with no edge. Assumes the primary clock is slower
// than half the backup clock. hold clears and freezes the state.
module cng_edge_watch #(
    parameter int SYNC_N   = 2,
    parameter int LOSS_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic pri_clk,
    output logic limp,
    output logic loss_evt
);
    localparam int GW = $clog2(LOSS_CYC + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(LOSS_CYC - 1);

    logic [SYNC_N:0] sync_q;
    logic [GW-1:0]   gap_q;
    logic            rise;

    // Synchroniser chain plus one stage for edge detection.
    genvar gi;
    generate
        for (gi = 0; gi <= SYNC_N; gi++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sync_q[gi] <= 1'b0;
                else if (gi == 0)
                    sync_q[gi] <= pri_clk;
                else
                    sync_q[gi] <= sync_q[(gi > 0) ? gi - 1 : 0];
            end
        end
    endgenerate

    assign rise     = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    assign loss_evt = !limp && !rise && !hold && (gap_q == GAP_LAST);

    // Gap counter: backup cycles since the last seen rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            gap_q <= '0;
        else if (rise)
            gap_q <= '0;
        else if (gap_q != GAP_LAST)
            gap_q <= gap_q + GW'(1);
    end

    // Limp latch: set on loss, held until any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            limp <= 1'b0;
        else if (loss_evt)
            limp <= 1'b1;
    end
endmodule

// File: rtl/cng_nmi_ctrl.sv
// NMI control: holds the interrupt flag, the sticky missing-clock bit and
// the delay counter, and requests a reset under the selected policy.
// Assumes loss_evt is a single-cycle event and hold covers a reset pulse.
module cng_nmi_ctrl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          loss_evt,
    input  logic          clr_req,
    input  logic          rst_sel,
    input  logic [CW-1:0] period,
    output logic          nmi_flag,
    output logic          miss_sts,
    output logic [CW-1:0] count,
    output logic          fire
);
    // Flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            nmi_flag <= 1'b0;
            miss_sts <= 1'b0;
        end else if (loss_evt) begin
            nmi_flag <= 1'b1;
            miss_sts <= 1'b1;
        end else if (clr_req) begin
            nmi_flag <= 1'b0;
        end
    end

    // Delay counter: runs only while the flag is set, saturates at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || loss_evt || clr_req)
            count <= '0;
        else if (nmi_flag && (count != '1))
            count <= count + CW'(1);
    end

    assign fire = nmi_flag && (rst_sel || (count == period));
endmodule

// File: rtl/cng_rst_pulse.sv
// Reset pulse generator: turns a fire request into a pulse PULSE_W
// backup cycles wide. Requests during a pulse are ignored.
module cng_rst_pulse #(
    parameter int PULSE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic rst_out
);
    localparam int PCW = $clog2(PULSE_W + 1);

    logic [PCW-1:0] left_q;

    // Down-counter: loaded on a request, counts the pulse out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (left_q != '0)
            left_q <= left_q - PCW'(1);
        else if (fire)
            left_q <= PCW'(PULSE_W);
    end

    assign rst_out = (left_q != '0);
endmodule

// File: rtl/cng_regs.sv
// Register port: holds the policy bit and period, decodes the clear
// strobe, and muxes the read data. Reads are combinational on addr.
module cng_regs
    import cng_pkg::*;
#(
    parameter int DW         = 16,
    parameter int CW         = 16,
    parameter int DEF_PERIOD = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          nmi_flag,
    input  logic          miss_sts,
    input  logic          limp,
    input  logic [CW-1:0] count,
    output logic [DW-1:0] rdata,
    output logic          rst_sel,
    output logic [CW-1:0] period,
    output logic          clr_req
);
    reg_addr_e a;
    assign a = reg_addr_e'(addr);

    assign clr_req = wr_en && (a == A_STAT) && wdata[0];

    // Configuration registers, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_sel <= 1'b0;
            period  <= CW'(DEF_PERIOD);
        end else if (wr_en) begin
            if (a == A_CTRL)   rst_sel <= wdata[0];
            if (a == A_PERIOD) period  <= wdata[CW-1:0];
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (a)
            A_STAT: begin
                rdata[ST_NMI]  = nmi_flag;
                rdata[ST_MISS] = miss_sts;
                rdata[ST_LIMP] = limp;
            end
            A_CTRL:   rdata[0]      = rst_sel;
            A_PERIOD: rdata[CW-1:0] = period;
            default:  rdata[CW-1:0] = count;
        endcase
    end
endmodule

// File: rtl/clkloss_nmi_guard.sv
// Top: missing clock guard. Watches pri_clk on bk_clk, switches sys_clk to
// limp_clk on loss, raises the NMI and status flags, and resets the device
// at once or after a programmed delay. Assumes bk_clk never stops and
// rst_n is synchronous to bk_clk. The output clock mux is a plain select
// and does not filter glitches.
module clkloss_nmi_guard #(
    parameter int SYNC_N     = 2,
    parameter int LOSS_CYC   = 16,
    parameter int DW         = 16,
    parameter int CW         = 16,
    parameter int PULSE_W    = 8,
    parameter int DEF_PERIOD = 100
) (
    input  logic          bk_clk,
    input  logic          rst_n,
    input  logic          pri_clk,
    input  logic          limp_clk,
    output logic          sys_clk,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rst_out
);
    logic          limp, loss_evt, nmi_flag, miss_sts, fire, clr_req, rst_sel;
    logic [CW-1:0] nmi_count, period;

    cng_edge_watch #(.SYNC_N(SYNC_N), .LOSS_CYC(LOSS_CYC)) u_watch (
        .clk(bk_clk), .rst_n(rst_n), .hold(rst_out), .pri_clk(pri_clk),
        .limp(limp), .loss_evt(loss_evt)
    );

    cng_nmi_ctrl #(.CW(CW)) u_nmi (
        .clk(bk_clk), .rst_n(rst_n), .hold(rst_out), .loss_evt(loss_evt),
        .clr_req(clr_req), .rst_sel(rst_sel), .period(period),
        .nmi_flag(nmi_flag), .miss_sts(miss_sts), .count(nmi_count), .fire(fire)
    );

    cng_rst_pulse #(.PULSE_W(PULSE_W)) u_pulse (
        .clk(bk_clk), .rst_n(rst_n), .fire(fire), .rst_out(rst_out)
    );

    cng_regs #(.DW(DW), .CW(CW), .DEF_PERIOD(DEF_PERIOD)) u_regs (
        .clk(bk_clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .nmi_flag(nmi_flag), .miss_sts(miss_sts), .limp(limp), .count(nmi_count),
        .rdata(rdata), .rst_sel(rst_sel), .period(period), .clr_req(clr_req)
    );

    // Output clock select.
    assign sys_clk = limp ? limp_clk : pri_clk;
endmodule

// File: rtl/clkloss_nmi_guard_chk.sv
// Checker: timing and state properties of the guard, bound to the top.
module clkloss_nmi_guard_chk #(
    parameter int DW      = 16,
    parameter int CW      = 16,
    parameter int PULSE_W = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rst_out,
    input logic          nmi_flag,
    input logic          miss_sts,
    input logic          limp,
    input logic          rst_sel,
    input logic [CW-1:0] count,
    input logic          wr_en,
    input logic [1:0]    addr,
    input logic [DW-1:0] wdata
);
    localparam int HW = $clog2(PULSE_W + 2);

    logic [HW-1:0] hi_cnt;
    logic          clr_wr;

    assign clr_wr = wr_en && (addr == 2'd0) && wdata[0];

    // Length of the current run of high reset output.
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_out)
            hi_cnt <= '0;
        else if (hi_cnt != '1)
            hi_cnt <= hi_cnt + HW'(1);
    end

    p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_out) && hi_cnt != '0) |-> hi_cnt == HW'(PULSE_W));

    p_immediate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_sel && nmi_flag && !rst_out) |=> rst_out);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && limp && !rst_out) |=> (!nmi_flag && count == '0));

    p_pulse_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> (!nmi_flag && !miss_sts && !limp && count == '0));

    p_sts_follows_nmi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_flag |-> miss_sts);

    p_limp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (limp && !rst_out) |=> limp);

    p_nmi_with_limp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_flag) |-> $rose(limp));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_flag && !rst_out && !clr_wr && count != '1)
            |=> count == $past(count) + CW'(1));
endmodule

bind clkloss_nmi_guard clkloss_nmi_guard_chk #(.DW(DW), .CW(CW), .PULSE_W(PULSE_W)) u_chk (
    .clk(bk_clk), .rst_n(rst_n), .rst_out(rst_out), .nmi_flag(nmi_flag),
    .miss_sts(miss_sts), .limp(limp), .rst_sel(rst_sel), .count(nmi_count),
    .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/clkloss_nmi_guard_tb.sv
`timescale 1ns/1ps
module clkloss_nmi_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pri_clk = 1'b0;
    logic        limp_clk = 1'b0;
    logic        sys_clk, rst_out;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, last_rise = 0, pri_half = 0, ph_cnt = 0;

    clkloss_nmi_guard u_dut (
        .bk_clk(clk), .rst_n(rst_n), .pri_clk(pri_clk), .limp_clk(limp_clk),
        .sys_clk(sys_clk), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rst_out(rst_out)
    );

    always #4 clk = ~clk;

    // Cycle counter, primary clock generator and limp clock, all driven on posedge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            limp_clk <= ~limp_clk;
            if (pri_half != 0) begin
                ph_cnt++;
                if (ph_cnt >= pri_half) begin
                    ph_cnt = 0;
                    if (!pri_clk) last_rise = cyc;
                    pri_clk <= ~pri_clk;
                end
            end
        end
    end

    function automatic int exp_delay(bit sel, int per);
        return sel ? 1 : per + 1;
    endfunction

    function automatic logic [2:0] exp_stat(bit limp, bit miss, bit nmi);
        return {limp, miss, nmi};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = 2'd0;
        #1;
    endtask

    // Waits for the NMI flag; returns its cycle, or -1 on timeout.
    task automatic wait_flag(output int at);
        at = -1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rdata[0]) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic stop_and_time(input bit sel, input int per);
        int at, d;
        pri_half = 0;
        wait_flag(at);
        check(at != -1, "R3 flag seen", at, 0);
        pri_half = 3;
        d = 0;
        while (!rst_out && d < 2000) begin
            @(negedge clk);
            d++;
        end
        check(d == exp_delay(sel, per), sel ? "R5 delay" : "R6 delay", d, exp_delay(sel, per));
        repeat (12) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        int at, w;
        void'($urandom(32'd7011));
        do_reset();

        // Reset state (R10)
        @(negedge clk);
        check(rdata[2:0] == 3'b000, "R10 status", rdata[2:0], 0);
        rd(2'd1, v); check(v == 16'd0, "R10 ctrl", v, 0);
        rd(2'd2, v); check(v == 16'd100, "R10 period", v, 100);
        rd(2'd3, v); check(v == 16'd0, "R10 count", v, 0);
        check(rst_out == 1'b0, "R10 rst_out", rst_out, 0);

        // No false loss for edge spacing <= 16 cycles (R1, R2)
        for (int k = 0; k < 6; k++) begin
            int ok_cnt;
            pri_half = (k == 0) ? 8 : $urandom_range(1, 8);
            ok_cnt = 0;
            for (int i = 0; i < 120; i++) begin
                @(negedge clk);
                if (rdata[2] == 1'b0 && sys_clk == pri_clk) ok_cnt++;
            end
            check(ok_cnt == 120, "R1 no false loss", ok_cnt, 120);
        end

        // Detection latency and flags (R1, R2, R3, R4)
        pri_half = 3;
        repeat (20) @(negedge clk);
        pri_half = 0;
        w = 0;
        while (!rdata[2] && w < 60) begin
            @(negedge clk);
            w++;
        end
        check(cyc - last_rise == 19, "R1 latency", cyc - last_rise, 19);
        check(rdata[2:0] == exp_stat(1, 1, 1), "R3 R4 status at loss", rdata[2:0], 7);
        check(sys_clk == limp_clk, "R2 limp select", sys_clk, limp_clk);
        pri_half = 3;
        repeat (4) @(negedge clk);
        check(rdata[2] == 1'b1 && sys_clk == limp_clk, "R2 limp held", rdata[2], 1);

        // Immediate policy, pulse width, pulse clearing (R5, R8, R9)
        do_reset();
        wr(2'd1, 16'd1);
        pri_half = 3;
        repeat (20) @(negedge clk);
        pri_half = 0;
        wait_flag(at);
        pri_half = 3;
        @(negedge clk);
        check(rst_out == 1'b1, "R5 immediate", rst_out, 1);
        w = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rst_out) w++; else break;
        end
        check(w == 8, "R8 width", w, 8);
        check(rdata[2:0] == 3'b000, "R9 flags cleared", rdata[2:0], 0);
        rd(2'd1, v); check(v == 16'd1, "R9 ctrl kept", v, 1);
        repeat (30) @(negedge clk);

        // Random policy and period (R5, R6)
        for (int k = 0; k < 10; k++) begin
            bit sel;
            int per;
            sel = (k < 2) ? 1'b0 : 1'($urandom_range(0, 1));
            per = (k == 0) ? 0 : $urandom_range(0, 60);
            wr(2'd1, {15'd0, sel});
            wr(2'd2, 16'(per));
            pri_half = $urandom_range(1, 5);
            repeat (30) @(negedge clk);
            stop_and_time(sel, per);
            rd(2'd2, v); check(v == 16'(per), "R9 period kept", v, per);
        end

        // Counter readback, no-effect write, software clear (R6, R7, R4)
        do_reset();
        wr(2'd2, 16'd1000);
        pri_half = 4;
        repeat (30) @(negedge clk);
        pri_half = 0;
        wait_flag(at);
        pri_half = 3;
        repeat (5) @(negedge clk);
        rd(2'd3, v); check(v == 16'(cyc - at), "R6 count", v, cyc - at);
        wr(2'd0, 16'hFFFE);
        check(rdata[2:0] == 3'b111, "R7 zero write ignored", rdata[2:0], 7);
        rd(2'd3, v); check(v == 16'(cyc - at), "R7 count kept", v, cyc - at);
        wr(2'd0, 16'h0001);
        check(rdata[2:0] == 3'b110, "R7 R4 clear", rdata[2:0], 6);
        rd(2'd3, v); check(v == 16'd0, "R7 count zero", v, 0);
        w = 0;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            if (rst_out) w++;
        end
        check(w == 0, "R7 no reset after clear", w, 0);
        check(rdata[1] == 1'b1, "R4 sticky", rdata[1], 1);

        // External reset clears all (R10)
        do_reset();
        @(negedge clk);
        check(rdata[2:0] == 3'b000, "R10 status after rst_n", rdata[2:0], 0);
        rd(2'd2, v); check(v == 16'd100, "R10 period restored", v, 100);

        summary();
    end
endmodule